// File: doc/BRIEF.md
# TDM / DSP Frame-Sync Slot Receiver

This block is the receive side of a bus slave on a time-division audio link. It runs on the externally supplied bit clock and watches two serial lines: a frame sync and a data line. A frame opens when the frame sync is seen rising. The width of the sync pulse does not matter, so a one-clock TDM strobe and a wide DSP-style pulse are handled the same way. From that point the block counts bit clocks to a configured start offset. It then shifts in a configured number of consecutive words, most significant bit first, and presents each finished word sign-extended to 32 bits, with the index of the word within the captured group and a one-cycle valid strobe.

Each slave on a shared TDM bus is given its own offset, so several receivers can pick different channels out of one frame. A delay option makes the first data bit of the frame arrive one bit clock after the sync edge. In this mode the last bit of a full frame falls on the next frame's sync edge, and the block still completes that word. The frame length is the slot width times the slot count. A sync edge that comes before that many bit clocks have passed is flagged as a framing error, and the block starts the new frame from that edge.

Top module: `tdm_slot_rx`

## Requirements
- R1: After reset `valid_o` and `frame_err_o` are 0 and `word_o` is 0. Serial data is ignored, and no word is produced, until the first rising edge of `fsync_i`.
- R2: A frame starts at the clock where `fsync_i` is sampled 1 after being 0. With `cfg_delay_i`=0, the data bit sampled at that same clock is frame bit 0. How long `fsync_i` stays high has no effect.
- R3: With `cfg_delay_i`=1, frame bit 0 is the data bit sampled one clock after the sync edge, and every later bit shifts by one clock. If the next sync edge comes exactly one frame length later, the final bit of the frame is taken at that edge and its word is still delivered.
- R4: Capture starts at frame bit `cfg_offset_i` and takes `cfg_count_i` consecutive words of `cfg_width_i` bits each (8 to 32), each received MSB first.
- R5: A word appears on `word_o`, sign-extended from its bit `cfg_width_i`-1 to 32 bits, with `valid_o`=1 for exactly one clock. That clock is the one after the word's last bit is sampled. `chan_o` gives the word's position in the captured group: 0 for the first word, up to `cfg_count_i`-1.
- R6: The frame length is `cfg_width_i` × `cfg_slots_i` bits. A word whose bits would run past the end of the frame is never delivered. Sync edges that arrive at or after the full frame length raise no error, and idle gaps between frames are allowed.
- R7: A sync edge that arrives fewer than a frame length of clocks after the previous frame start sets `frame_err_o` to 1 for one clock, in the clock after that edge. The unfinished word is discarded, and the edge starts a new frame.
- R8: With `cfg_count_i`=0, no word is ever delivered.
- R9: In two-channel DSP framing (2 slots, offset 0, count 2) the left word (`chan_o`=0) and the right word (`chan_o`=1) are delivered from back-to-back slots, one slot width apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data and frame sync sampled on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame sync; its rising edge opens a frame |
| sdata_i | input | 1 | Serial data, MSB first |
| cfg_width_i | input | 6 | Slot and word width in bits, 8 to 32 |
| cfg_slots_i | input | 5 | Slots per frame, 1 to 16 |
| cfg_offset_i | input | 9 | Frame bit at which capture starts |
| cfg_count_i | input | 5 | Number of consecutive words to capture, 0 to 16 |
| cfg_delay_i | input | 1 | 1 = first data bit one bit clock after the sync edge |
| word_o | output | 32 | Captured word, sign-extended |
| chan_o | output | 4 | Index of the word within the captured group |
| valid_o | output | 1 | One-clock strobe marking a new word |
| frame_err_o | output | 1 | One-clock pulse on a premature sync edge |

## Verification
Two events can fall on the same bit clock: the sampling of a word's final bit and a sync edge. The outcome depends on the kind of edge. A premature edge on that clock must discard the word and raise the error pulse. An edge that arrives exactly on time in the delayed-data mode must let the word finish while the new frame starts. The bench builds frame streams that put a premature edge on the last bit of a word, and streams in which the final bit of a full frame in delay mode coincides with the next edge. It then compares each delivered word, its index and its arrival clock, and every error pulse, against a list computed from the requirements.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    parameter int unsigned WORD_MAX  = 32;
    parameter int unsigned SLOTS_MAX = 16;

    // Per-bit directive from the framer to the deserializer.
    typedef struct packed {
        logic take;     // this bit lies inside the capture window
        logic fresh;    // this bit belongs to a frame that starts now
        logic restart;  // clear the word counters after this bit
    } bit_ctl_t;
endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fsync_i,
    output logic rise_o
);
    logic sync_d, sync_q;

    always_comb begin
        sync_d = fsync_i;
        rise_o = fsync_i & ~sync_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= sync_d;
    end
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int WORD_MAX  = tdm_rx_pkg::WORD_MAX,
    parameter int SLOTS_MAX = tdm_rx_pkg::SLOTS_MAX,
    localparam int CNT_W    = $clog2(WORD_MAX * SLOTS_MAX + 2),
    localparam int WIDTH_W  = $clog2(WORD_MAX + 1),
    localparam int SLOT_W   = $clog2(SLOTS_MAX + 1),
    localparam int OFF_W    = CNT_W - 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rise_i,
    input  logic [WIDTH_W-1:0] cfg_width_i,
    input  logic [SLOT_W-1:0]  cfg_slots_i,
    input  logic [OFF_W-1:0]   cfg_offset_i,
    input  logic               cfg_delay_i,
    output bit_ctl_t           ctl_o,
    output logic               err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;   // frame clock of the next bit
        logic             run;   // at least one frame has started
        logic             err;
    } frm_t;

    frm_t frm_d, frm_q;

    logic [CNT_W-1:0] flen, limit, here, data_idx, dly;
    logic             tail, fresh, live;

    always_comb begin
        dly   = CNT_W'(cfg_delay_i);
        flen  = CNT_W'(cfg_width_i) * CNT_W'(cfg_slots_i);
        limit = flen + dly;
        // With delayed data the last bit of a full frame shares a clock
        // with the next sync edge; that bit still belongs to the old frame.
        tail  = rise_i & cfg_delay_i & frm_q.run & (frm_q.pos == flen);
        fresh = rise_i & ~tail;
        here  = fresh ? '0 : frm_q.pos;
        live  = fresh | (frm_q.run & (frm_q.pos < limit));
        data_idx = here - dly;

        ctl_o.take    = live & (here >= dly) & (data_idx >= CNT_W'(cfg_offset_i))
                        & (data_idx < flen);
        ctl_o.fresh   = fresh;
        ctl_o.restart = tail;

        frm_d     = frm_q;
        frm_d.err = rise_i & frm_q.run & (frm_q.pos < flen);
        frm_d.run = frm_q.run | rise_i;
        if (rise_i)    frm_d.pos = CNT_W'(1);
        else if (live) frm_d.pos = frm_q.pos + CNT_W'(1);

        err_o = frm_q.err;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) frm_q <= '0;
        else         frm_q <= frm_d;
    end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_rx_pkg::*;
#(
    parameter int WORD_MAX  = tdm_rx_pkg::WORD_MAX,
    parameter int SLOTS_MAX = tdm_rx_pkg::SLOTS_MAX,
    localparam int WIDTH_W  = $clog2(WORD_MAX + 1),
    localparam int SLOT_W   = $clog2(SLOTS_MAX + 1),
    localparam int CHAN_W   = $clog2(SLOTS_MAX)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sdata_i,
    input  bit_ctl_t            ctl_i,
    input  logic [WIDTH_W-1:0]  cfg_width_i,
    input  logic [SLOT_W-1:0]   cfg_count_i,
    output logic [WORD_MAX-1:0] word_o,
    output logic [CHAN_W-1:0]   chan_o,
    output logic                valid_o
);
    typedef struct packed {
        logic [WORD_MAX-2:0] shift;
        logic [WIDTH_W-1:0]  bitn;
        logic [SLOT_W-1:0]   wordn;
        logic [WORD_MAX-1:0] word;
        logic [CHAN_W-1:0]   chan;
        logic                valid;
    } des_t;

    des_t des_d, des_q;

    logic [WIDTH_W-1:0]  b_cur, b_nxt, pad;
    logic [SLOT_W-1:0]   c_cur, c_nxt;
    logic [WORD_MAX-1:0] joined, aligned;
    logic                grab;

    always_comb begin
        b_cur   = ctl_i.fresh ? '0 : des_q.bitn;
        c_cur   = ctl_i.fresh ? '0 : des_q.wordn;
        grab    = ctl_i.take & (c_cur < cfg_count_i);
        joined  = {des_q.shift, sdata_i};
        pad     = WIDTH_W'(WORD_MAX) - cfg_width_i;
        aligned = joined << pad;
        b_nxt   = b_cur;
        c_nxt   = c_cur;

        des_d       = des_q;
        des_d.valid = 1'b0;
        if (grab) begin
            des_d.shift = joined[WORD_MAX-2:0];
            if (b_cur == cfg_width_i - WIDTH_W'(1)) begin
                des_d.valid = 1'b1;
                des_d.word  = WORD_MAX'($signed(aligned) >>> pad);
                des_d.chan  = c_cur[CHAN_W-1:0];
                b_nxt       = '0;
                c_nxt       = c_cur + SLOT_W'(1);
            end else begin
                b_nxt = b_cur + WIDTH_W'(1);
            end
        end
        des_d.bitn  = ctl_i.restart ? '0 : b_nxt;
        des_d.wordn = ctl_i.restart ? '0 : c_nxt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) des_q <= '0;
        else         des_q <= des_d;
    end

    assign word_o  = des_q.word;
    assign chan_o  = des_q.chan;
    assign valid_o = des_q.valid;
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter int WORD_MAX  = tdm_rx_pkg::WORD_MAX,
    parameter int SLOTS_MAX = tdm_rx_pkg::SLOTS_MAX,
    localparam int CNT_W    = $clog2(WORD_MAX * SLOTS_MAX + 2),
    localparam int WIDTH_W  = $clog2(WORD_MAX + 1),
    localparam int SLOT_W   = $clog2(SLOTS_MAX + 1),
    localparam int CHAN_W   = $clog2(SLOTS_MAX),
    localparam int OFF_W    = CNT_W - 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                fsync_i,
    input  logic                sdata_i,
    input  logic [WIDTH_W-1:0]  cfg_width_i,
    input  logic [SLOT_W-1:0]   cfg_slots_i,
    input  logic [OFF_W-1:0]    cfg_offset_i,
    input  logic [SLOT_W-1:0]   cfg_count_i,
    input  logic                cfg_delay_i,
    output logic [WORD_MAX-1:0] word_o,
    output logic [CHAN_W-1:0]   chan_o,
    output logic                valid_o,
    output logic                frame_err_o
);
    logic     rise;
    bit_ctl_t ctl;

    tdm_rx_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fsync_i (fsync_i),
        .rise_o  (rise)
    );

    tdm_rx_framer #(.WORD_MAX(WORD_MAX), .SLOTS_MAX(SLOTS_MAX)) u_framer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rise_i       (rise),
        .cfg_width_i  (cfg_width_i),
        .cfg_slots_i  (cfg_slots_i),
        .cfg_offset_i (cfg_offset_i),
        .cfg_delay_i  (cfg_delay_i),
        .ctl_o        (ctl),
        .err_o        (frame_err_o)
    );

    tdm_rx_deser #(.WORD_MAX(WORD_MAX), .SLOTS_MAX(SLOTS_MAX)) u_deser (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sdata_i     (sdata_i),
        .ctl_i       (ctl),
        .cfg_width_i (cfg_width_i),
        .cfg_count_i (cfg_count_i),
        .word_o      (word_o),
        .chan_o      (chan_o),
        .valid_o     (valid_o)
    );
endmodule

// File: rtl/tdm_rx_checker.sv
module tdm_rx_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        fsync_i,
    input logic [5:0]  cfg_width_i,
    input logic [4:0]  cfg_count_i,
    input logic [31:0] word_o,
    input logic [3:0]  chan_o,
    input logic        valid_o,
    input logic        frame_err_o
);
    // R5: a word strobe lasts one clock (words are at least 8 bits apart)
    p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R5: delivered word is a sign extension of its top received bit
    p_sign_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ((($signed(word_o) >>> (cfg_width_i - 6'd1)) == 32'sd0) ||
                     (($signed(word_o) >>> (cfg_width_i - 6'd1)) == -32'sd1)));

    // R4: index stays inside the captured group
    p_chan_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ({1'b0, chan_o} < cfg_count_i));

    // R7: an error follows a sync that was high on the previous clock
    p_err_after_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |-> $past(fsync_i));

    // R7: error is a single-clock pulse
    p_err_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |=> !frame_err_o);

    // R8: an empty capture group yields nothing
    p_no_words_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_count_i == 5'd0) && $stable(cfg_count_i) |-> !valid_o);
endmodule

bind tdm_slot_rx tdm_rx_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fsync_i     (fsync_i),
    .cfg_width_i (cfg_width_i),
    .cfg_count_i (cfg_count_i),
    .word_o      (word_o),
    .chan_o      (chan_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
);

// File: tb/tdm_slot_rx_tb.sv
module tdm_slot_rx_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_ni, fsync_i, sdata_i, cfg_delay_i;
    logic [5:0]  cfg_width_i;
    logic [4:0]  cfg_slots_i, cfg_count_i;
    logic [8:0]  cfg_offset_i;
    logic [31:0] word_o;
    logic [3:0]  chan_o;
    logic        valid_o, frame_err_o;

    tdm_slot_rx u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fsync_i), .sdata_i(sdata_i),
        .cfg_width_i(cfg_width_i), .cfg_slots_i(cfg_slots_i),
        .cfg_offset_i(cfg_offset_i), .cfg_count_i(cfg_count_i),
        .cfg_delay_i(cfg_delay_i), .word_o(word_o), .chan_o(chan_o),
        .valid_o(valid_o), .frame_err_o(frame_err_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit fs_s [0:4095];
    bit sd_s [0:4095];
    bit e_err[0:4095];
    logic [31:0] e_word[0:255];
    int e_chan[0:255];
    int e_clk[0:255];
    int ne, nclk, nst, fsw;
    int st[0:7];
    int tw, tns, toff, tcnt, tdly;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [31:0] v, input int w);
        logic [31:0] m;
        m = v << (32 - w);
        return $signed(m) >>> (32 - w);
    endfunction

    task automatic setup(input int w, input int ns, input int off, input int cnt,
                         input int dly, input int fw);
        tw = w; tns = ns; toff = off; tcnt = cnt; tdly = dly; fsw = fw;
        @(negedge clk);
        rst_ni = 1'b0; fsync_i = 1'b0; sdata_i = 1'b0;
        cfg_width_i = 6'(w); cfg_slots_i = 5'(ns); cfg_offset_i = 9'(off);
        cfg_count_i = 5'(cnt); cfg_delay_i = dly[0];
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
    endtask

    // Builds the serial stream for frames starting at st[0..nst-1] and the
    // expected words/errors derived from the requirements.
    task automatic build();
        int flen;
        bit fb[0:511];
        flen = tw * tns;
        nclk = st[nst-1] + flen + tdly + 4;
        for (int i = 0; i < 4096; i++) begin
            fs_s[i] = 0; sd_s[i] = 0; e_err[i] = 0;
        end
        ne = 0;
        for (int f = 0; f < nst; f++) begin
            int s, nxt;
            s = st[f];
            nxt = (f + 1 < nst) ? st[f+1] : 100000;
            for (int i = 0; i < fsw; i++) fs_s[s+i] = 1;
            for (int d = 0; d < flen; d++) begin
                fb[d] = 1'($urandom);
                sd_s[s+tdly+d] = fb[d];
            end
            if (f > 0 && (s - st[f-1]) < flen) e_err[s+1] = 1;
            for (int k = 0; k < tcnt; k++) begin
                int a, last;
                logic [31:0] v;
                a = toff + k * tw;
                last = s + tdly + a + tw - 1;
                if (a + tw <= flen &&
                    (last < nxt || (last == nxt && (nxt - s) >= flen))) begin
                    v = '0;
                    for (int j = 0; j < tw; j++) v = {v[30:0], fb[a+j]};
                    e_word[ne] = sx(v, tw);
                    e_chan[ne] = k;
                    e_clk[ne]  = last + 1;
                    ne++;
                end
            end
        end
    endtask

    task automatic run(input string tag);
        int ptr;
        ptr = 0;
        for (int c = 0; c < nclk; c++) begin
            @(negedge clk);
            if (valid_o) begin
                if (ptr < ne) begin
                    chk(word_o == e_word[ptr] && 32'(chan_o) == e_chan[ptr] &&
                        c == e_clk[ptr], tag, $sformatf("word %0d chan %0d clk %0d", ptr, chan_o, c),
                        word_o, e_word[ptr]);
                    ptr++;
                end else begin
                    chk(0, tag, "unexpected word", word_o, 0);
                end
            end else if (ptr < ne && e_clk[ptr] == c) begin
                chk(0, tag, $sformatf("missing word %0d at clk %0d", ptr, c), 0, e_word[ptr]);
                ptr++;
            end
            if (frame_err_o || e_err[c])
                chk(frame_err_o == e_err[c], tag, $sformatf("frame error clk %0d", c),
                    32'(frame_err_o), 32'(e_err[c]));
            fsync_i = fs_s[c];
            sdata_i = sd_s[c];
        end
        chk(ptr == ne, tag, "words delivered", ptr, ne);
    endtask

    // R1: reset state, data ignored before the first sync edge
    task automatic t_reset();
        int seen;
        setup(8, 2, 0, 2, 0, 1);
        @(negedge clk);
        chk(valid_o == 0, "R1", "valid after reset", 32'(valid_o), 0);
        chk(frame_err_o == 0, "R1", "error after reset", 32'(frame_err_o), 0);
        chk(word_o == 0, "R1", "word after reset", word_o, 0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            sdata_i = 1'($urandom);
            @(negedge clk);
            if (valid_o || frame_err_o) seen++;
        end
        chk(seen == 0, "R1", "output without sync", seen, 0);
    endtask

    // R9, R2: two-channel DSP, wide sync pulse, one idle gap
    task automatic t_dsp();
        setup(16, 2, 0, 2, 0, 5);
        nst = 4; st[0] = 2; st[1] = 34; st[2] = 66; st[3] = 110;
        build();
        run("R9");
    endtask

    // R3: delayed data, back-to-back frames, final bit on next sync edge
    task automatic t_delay();
        setup(8, 4, 8, 3, 1, 1);
        nst = 3; st[0] = 1; st[1] = 33; st[2] = 65;
        build();
        run("R3");
    endtask

    // R4, R2: TDM with one-clock sync, capture slots 2 and 3 of 8
    task automatic t_tdm();
        setup(24, 8, 48, 2, 0, 1);
        nst = 2; st[0] = 0; st[1] = 192;
        build();
        run("R4");
    endtask

    // R6: words past frame end dropped, late edges give no error
    task automatic t_trunc();
        setup(12, 3, 20, 3, 0, 3);
        nst = 3; st[0] = 0; st[1] = 41; st[2] = 82;
        build();
        run("R6");
    endtask

    // R7: premature edge lands on the final bit of a word
    task automatic t_early();
        setup(8, 4, 0, 4, 0, 2);
        nst = 4; st[0] = 0; st[1] = 32; st[2] = 55; st[3] = 87;
        build();
        run("R7");
    endtask

    // R8: empty capture group
    task automatic t_zero();
        setup(8, 2, 0, 0, 0, 1);
        nst = 2; st[0] = 0; st[1] = 16;
        build();
        run("R8");
    endtask

    // R5: 32-bit words, last slot of 16 in delay mode
    task automatic t_wide();
        setup(32, 16, 480, 1, 1, 1);
        nst = 2; st[0] = 0; st[1] = 512;
        build();
        run("R5");
    endtask

    initial begin
        rst_ni = 1'b0; fsync_i = 1'b0; sdata_i = 1'b0; cfg_delay_i = 1'b0;
        cfg_width_i = 6'd8; cfg_slots_i = 5'd2; cfg_offset_i = '0; cfg_count_i = 5'd2;
        t_reset();
        t_dsp();
        t_delay();
        t_tdm();
        t_trunc();
        t_early();
        t_zero();
        t_wide();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule